// File: doc/BRIEF.md
# UART Hardware Flow Control Unit

This unit automates modem-line handshaking for a UART. It sits between the receive FIFO, the transmit engine and the two handshake pins. On the receive side it watches the FIFO fill count. It drives the active-low ready-to-send output with programmable hysteresis and raises a receive-trigger interrupt. On the transmit side it synchronises the active-low clear-to-send input. From that input it decides whether the transmit engine may start the next character.

Three small state machines do the work.

- **Ready-to-send machine** (`rts_fsm`) has three states:
  - `RTS_SW`: the pin follows the software request bit.
  - `RTS_ON`: automatic control, pin asserted low.
  - `RTS_OFF`: automatic control, pin de-asserted high.
  - Transitions:
    - From any state to `RTS_SW` when automatic mode is off or the software bit is clear.
    - `RTS_SW` to `RTS_ON` when both automatic mode and the software bit are set.
    - `RTS_ON` to `RTS_OFF` when the fill count reaches the upper threshold.
    - `RTS_OFF` to `RTS_ON` when the fill count drops below the lower threshold.
- **Interrupt machine** (`irq_fsm`) has three states:
  - `IRQ_ARMED`: waiting for the fill to reach the trigger.
  - `IRQ_PEND`: interrupt asserted.
  - `IRQ_SPENT`: cleared by software while the fill is still at or above the trigger.
  - Transitions:
    - `IRQ_ARMED` to `IRQ_PEND` when the fill reaches the trigger in automatic mode.
    - `IRQ_PEND` to `IRQ_ARMED` when the fill drops below the trigger.
    - `IRQ_PEND` to `IRQ_SPENT` on a software clear.
    - `IRQ_SPENT` to `IRQ_ARMED` when the fill drops below the trigger.
- **Transmit gate** (`tx_gate_fsm`) has three states:
  - `TX_OPEN`: not blocked.
  - `TX_DRAIN`: blocked while a character is still shifting.
  - `TX_HOLD`: blocked at a character boundary.
  - Transitions:
    - `TX_OPEN` to `TX_HOLD` when blocked and the transmitter is idle.
    - `TX_OPEN` to `TX_DRAIN` when blocked and the transmitter is busy.
    - `TX_DRAIN` to `TX_HOLD` when the character finishes.
    - `TX_DRAIN` to `TX_OPEN` when no longer blocked.
    - `TX_HOLD` to `TX_OPEN` when no longer blocked.

Top module: `uart_hwflow`

## Requirements
- R1: After reset, `irq` is 0 and `tx_allow` is 1. `rts_n` equals the inverse of `sw_rts` (with `sw_rts` = 0, `rts_n` = 1).
- R2: With `auto_rts_en` = 0, `rts_n` is the combinational inverse of `sw_rts`, whatever `rx_count` is.
- R3: With `auto_rts_en` = 1 and `sw_rts` = 1, `rts_n` stays 0 while `rx_count` < `hyst_hi`. `rts_n` becomes 1 one clock edge after `rx_count` >= `hyst_hi`.
- R4: Once automatically de-asserted, `rts_n` stays 1 while `rx_count` >= `hyst_lo`. It returns to 0 one edge after `rx_count` < `hyst_lo`. Between the thresholds the pin holds its current level in both sweep directions. The configuration must obey `hyst_lo` < `trig_lvl` <= `hyst_hi` <= FIFO depth.
- R5: With `auto_rts_en` = 1 but `sw_rts` = 0, `rts_n` stays 1 at every fill level. Automatic control starts only after `sw_rts` is set.
- R6: With `auto_rts_en` = 1, `irq` rises one edge after `rx_count` >= `trig_lvl`. With `auto_rts_en` = 0 it never rises.
- R7: `irq` stays 1 until `rx_count` < `trig_lvl` or a one-cycle `irq_clr` pulse; it falls one edge after either. After a clear it is not raised again until the fill has dropped below the trigger and reached it again.
- R8: With `auto_cts_en` = 1 and `tx_idle` = 1, `tx_allow` falls two edges after `cts_n` rises, through the two-flop synchroniser. It rises two edges after `cts_n` falls.
- R9: While `tx_idle` = 0 (a character shifting), `tx_allow` stays 1 even when `cts_n` is high. It falls in the same cycle that `tx_idle` rises if still blocked.
- R10: With `auto_cts_en` = 0, `cts_n` has no effect and `tx_allow` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_rts_en | input | 1 | Enables automatic ready-to-send control and the trigger interrupt |
| auto_cts_en | input | 1 | Enables clear-to-send transmit gating |
| sw_rts | input | 1 | Software request: 1 asserts `rts_n` low |
| trig_lvl | input | CNT_W | Receive trigger level |
| hyst_hi | input | CNT_W | Upper threshold: de-assert at or above it |
| hyst_lo | input | CNT_W | Lower threshold: re-assert below it |
| rx_count | input | CNT_W | Receive FIFO fill count |
| irq_clr | input | 1 | One-cycle software clear of the interrupt |
| cts_n | input | 1 | Asynchronous clear-to-send pin, active low |
| tx_idle | input | 1 | 1 when the transmitter is between characters |
| rts_n | output | 1 | Ready-to-send pin, active low |
| tx_allow | output | 1 | 1 lets the transmit engine run or start a character |
| irq | output | 1 | Receive-trigger interrupt |

## Verification
The bench sweeps the fill count up through the trigger and upper threshold, then down through the band and below the lower threshold. A design that compared with the wrong threshold, or that let go of the hysteresis band, would toggle `rts_n` inside the band. Clear-to-send is raised in the middle of a character. A gate that ignored the character boundary would drop `tx_allow` mid-shift and corrupt the frame. The bench also clears the interrupt while the fill stays high, so an interrupt that re-fired from the level alone would show up at once. The exact synchroniser latency is checked one edge early and on time.

// File: rtl/hwflow_pkg.sv
package hwflow_pkg;
    typedef enum logic [1:0] {RTS_SW, RTS_ON, RTS_OFF} rts_state_e;
    typedef enum logic [1:0] {IRQ_ARMED, IRQ_PEND, IRQ_SPENT} irq_state_e;
    typedef enum logic [1:0] {TX_OPEN, TX_DRAIN, TX_HOLD} tx_state_e;
endpackage

// File: rtl/cts_sync.sv
module cts_sync #(
    parameter int    STAGES  = 2,
    parameter logic  RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] stage_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    stage_q[i] <= RST_VAL;
                else if (i == 0)
                    stage_q[i] <= din;
                else
                    stage_q[i] <= stage_q[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/rts_fsm.sv
module rts_fsm
    import hwflow_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             auto_en,
    input  logic             sw_rts,
    input  logic [CNT_W-1:0] trig_lvl,
    input  logic [CNT_W-1:0] hyst_hi,
    input  logic [CNT_W-1:0] hyst_lo,
    input  logic [CNT_W-1:0] rx_count,
    output logic             rts_n
);
    rts_state_e state, state_nx;
    logic       auto_live;

    assign auto_live = auto_en && sw_rts;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RTS_SW;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (!auto_live) begin
            state_nx = RTS_SW;
        end else begin
            unique case (state)
                RTS_SW:  state_nx = RTS_ON;
                RTS_ON:  if (rx_count >= hyst_hi) state_nx = RTS_OFF;
                RTS_OFF: if (rx_count < hyst_lo)  state_nx = RTS_ON;
                default: state_nx = RTS_SW;
            endcase
        end
    end

    always_comb begin
        unique case (state)
            RTS_SW:  rts_n = !sw_rts;
            RTS_ON:  rts_n = 1'b0;
            RTS_OFF: rts_n = 1'b1;
            default: rts_n = 1'b1;
        endcase
    end

    // R3
    upper_deassert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RTS_ON && auto_live && rx_count >= hyst_hi) |=> rts_n);
    // R4
    lower_reassert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RTS_OFF && auto_live && rx_count < hyst_lo) |=> !rts_n);
    // R4
    band_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RTS_OFF && auto_live && rx_count >= hyst_lo) |=> rts_n);
    // R2
    manual_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_en && $past(!auto_en)) |-> (rts_n == !sw_rts));
    // R4
    thresh_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        auto_en |-> (hyst_lo < trig_lvl && trig_lvl <= hyst_hi &&
                     hyst_hi <= CNT_W'(DEPTH)));
endmodule

// File: rtl/irq_fsm.sv
module irq_fsm
    import hwflow_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             auto_en,
    input  logic             irq_clr,
    input  logic [CNT_W-1:0] trig_lvl,
    input  logic [CNT_W-1:0] rx_count,
    output logic             irq
);
    irq_state_e state, state_nx;
    logic       at_trig;

    assign at_trig = (rx_count >= trig_lvl);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= IRQ_ARMED;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            IRQ_ARMED: if (auto_en && at_trig) state_nx = IRQ_PEND;
            IRQ_PEND: begin
                if (!at_trig)     state_nx = IRQ_ARMED;
                else if (irq_clr) state_nx = IRQ_SPENT;
            end
            IRQ_SPENT: if (!at_trig) state_nx = IRQ_ARMED;
            default:   state_nx = IRQ_ARMED;
        endcase
    end

    always_comb begin
        unique case (state)
            IRQ_PEND: irq = 1'b1;
            default:  irq = 1'b0;
        endcase
    end

    // R6
    raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == IRQ_ARMED && auto_en && at_trig) |=> irq);
    // R7
    clr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && irq_clr) |=> !irq);
    // R7
    level_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !at_trig) |=> !irq);
endmodule

// File: rtl/tx_gate_fsm.sv
module tx_gate_fsm
    import hwflow_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic auto_en,
    input  logic cts_n_sync,
    input  logic tx_idle,
    output logic tx_allow
);
    tx_state_e state, state_nx;
    logic      blocked;

    assign blocked = auto_en && cts_n_sync;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_OPEN;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            TX_OPEN:  if (blocked) state_nx = tx_idle ? TX_HOLD : TX_DRAIN;
            TX_DRAIN: begin
                if (!blocked)    state_nx = TX_OPEN;
                else if (tx_idle) state_nx = TX_HOLD;
            end
            TX_HOLD:  if (!blocked) state_nx = TX_OPEN;
            default:  state_nx = TX_OPEN;
        endcase
    end

    always_comb begin
        unique case (state)
            TX_OPEN:  tx_allow = !blocked || !tx_idle;
            TX_DRAIN: tx_allow = !blocked || !tx_idle;
            TX_HOLD:  tx_allow = !blocked;
            default:  tx_allow = 1'b1;
        endcase
    end

    // R9
    no_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_idle && $past(!tx_idle) && $past(tx_allow)) |-> tx_allow);
    // R8
    drain_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_DRAIN && tx_idle && blocked) |=> (state == TX_HOLD));
endmodule

// File: rtl/uart_hwflow.sv
module uart_hwflow #(
    parameter int FIFO_DEPTH  = 64,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             auto_rts_en,
    input  logic             auto_cts_en,
    input  logic             sw_rts,
    input  logic [CNT_W-1:0] trig_lvl,
    input  logic [CNT_W-1:0] hyst_hi,
    input  logic [CNT_W-1:0] hyst_lo,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             irq_clr,
    input  logic             cts_n,
    input  logic             tx_idle,
    output logic             rts_n,
    output logic             tx_allow,
    output logic             irq
);
    logic cts_n_s;

    cts_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(cts_n), .dout(cts_n_s)
    );

    rts_fsm #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_rts (
        .clk(clk), .rst_n(rst_n), .auto_en(auto_rts_en), .sw_rts(sw_rts),
        .trig_lvl(trig_lvl), .hyst_hi(hyst_hi), .hyst_lo(hyst_lo),
        .rx_count(rx_count), .rts_n(rts_n)
    );

    irq_fsm #(.CNT_W(CNT_W)) u_irq (
        .clk(clk), .rst_n(rst_n), .auto_en(auto_rts_en), .irq_clr(irq_clr),
        .trig_lvl(trig_lvl), .rx_count(rx_count), .irq(irq)
    );

    tx_gate_fsm u_tx (
        .clk(clk), .rst_n(rst_n), .auto_en(auto_cts_en), .cts_n_sync(cts_n_s),
        .tx_idle(tx_idle), .tx_allow(tx_allow)
    );
endmodule

// File: tb/uart_hwflow_test.sv
`timescale 1ns/1ps
module uart_hwflow_test;
    localparam int DEPTH = 64;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          auto_rts_en = 1'b0, auto_cts_en = 1'b0, sw_rts = 1'b0;
    logic [CW-1:0] trig_lvl = CW'(32), hyst_hi = CW'(40), hyst_lo = CW'(24);
    logic [CW-1:0] rx_count = '0;
    logic          irq_clr = 1'b0, cts_n = 1'b0, tx_idle = 1'b1;
    logic          rts_n, tx_allow, irq;
    int            checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    uart_hwflow #(.FIFO_DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .auto_rts_en(auto_rts_en),
        .auto_cts_en(auto_cts_en), .sw_rts(sw_rts), .trig_lvl(trig_lvl),
        .hyst_hi(hyst_hi), .hyst_lo(hyst_lo), .rx_count(rx_count),
        .irq_clr(irq_clr), .cts_n(cts_n), .tx_idle(tx_idle),
        .rts_n(rts_n), .tx_allow(tx_allow), .irq(irq)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 irq", irq, 1'b0);
        chk("R1 tx_allow", tx_allow, 1'b1);
        chk("R1 rts_n", rts_n, 1'b1);
    endtask

    task automatic t_rts_manual;
        auto_rts_en = 0; rx_count = CW'(64); sw_rts = 1; #1;
        chk("R2 sw assert", rts_n, 1'b0);
        step(2);
        chk("R2 full fifo ignored", rts_n, 1'b0);
        sw_rts = 0; #1;
        chk("R2 sw release", rts_n, 1'b1);
        rx_count = '0; step(1);
    endtask

    task automatic t_rts_sweep;
        auto_rts_en = 1; sw_rts = 1; rx_count = '0; step(1);
        chk("R3 auto start low", rts_n, 1'b0);
        rx_count = CW'(39); step(1);
        chk("R3 below upper", rts_n, 1'b0);
        rx_count = CW'(40); #1;
        chk("R3 no early deassert", rts_n, 1'b0);
        step(1);
        chk("R3 upper deassert", rts_n, 1'b1);
        rx_count = CW'(30); step(1);
        chk("R4 band hold high", rts_n, 1'b1);
        rx_count = CW'(24); step(1);
        chk("R4 at lower hold high", rts_n, 1'b1);
        rx_count = CW'(23); step(1);
        chk("R4 below lower reassert", rts_n, 1'b0);
        rx_count = CW'(35); step(1);
        chk("R4 band hold low", rts_n, 1'b0);
        rx_count = CW'(64); step(1);
        chk("R3 full deassert", rts_n, 1'b1);
        rx_count = '0; step(1);
        chk("R4 empty reassert", rts_n, 1'b0);
    endtask

    task automatic t_rts_needs_sw;
        auto_rts_en = 1; sw_rts = 0; rx_count = '0; step(1);
        chk("R5 no sw empty", rts_n, 1'b1);
        rx_count = CW'(64); step(1);
        rx_count = CW'(5); step(1);
        chk("R5 no sw after sweep", rts_n, 1'b1);
        sw_rts = 1; step(1);
        chk("R5 sw enables auto", rts_n, 1'b0);
    endtask

    task automatic t_irq;
        auto_rts_en = 1; sw_rts = 1; rx_count = '0; step(1);
        rx_count = CW'(31); step(1);
        chk("R6 below trigger", irq, 1'b0);
        rx_count = CW'(32); step(1);
        chk("R6 at trigger", irq, 1'b1);
        rx_count = CW'(33); step(1);
        chk("R7 stays pending", irq, 1'b1);
        rx_count = CW'(31); step(1);
        chk("R7 drop below trigger", irq, 1'b0);
        rx_count = CW'(32); step(1);
        chk("R7 re-raise", irq, 1'b1);
        irq_clr = 1; step(1); irq_clr = 0;
        chk("R7 software clear", irq, 1'b0);
        rx_count = CW'(40); step(1);
        chk("R7 no refire after clear", irq, 1'b0);
        rx_count = CW'(10); step(1);
        rx_count = CW'(32); step(1);
        chk("R7 rearmed", irq, 1'b1);
        rx_count = '0; step(1);
        auto_rts_en = 0; rx_count = CW'(50); step(2);
        chk("R6 off no irq", irq, 1'b0);
        rx_count = '0; step(1);
    endtask

    task automatic t_cts_idle;
        auto_cts_en = 1; tx_idle = 1; cts_n = 0; step(3);
        cts_n = 1; step(1);
        chk("R8 sync latency", tx_allow, 1'b1);
        step(1);
        chk("R8 blocked", tx_allow, 1'b0);
        cts_n = 0; step(1);
        chk("R8 still blocked", tx_allow, 1'b0);
        step(1);
        chk("R8 resumed", tx_allow, 1'b1);
    endtask

    task automatic t_cts_midchar;
        auto_cts_en = 1; tx_idle = 0; cts_n = 1; step(2);
        chk("R9 mid char kept", tx_allow, 1'b1);
        step(3);
        chk("R9 still shifting", tx_allow, 1'b1);
        tx_idle = 1; #1;
        chk("R9 drop at boundary", tx_allow, 1'b0);
        step(1);
        chk("R9 held at boundary", tx_allow, 1'b0);
        cts_n = 0; step(2);
        chk("R9 resumed", tx_allow, 1'b1);
        tx_idle = 0; cts_n = 1; step(1);
        cts_n = 0; step(3);
        tx_idle = 1; #1;
        chk("R9 glitch mid char", tx_allow, 1'b1);
    endtask

    task automatic t_cts_off;
        auto_cts_en = 0; tx_idle = 1; cts_n = 1; step(4);
        chk("R10 cts ignored", tx_allow, 1'b1);
        cts_n = 0; step(1);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1;
        step(1);
        t_reset();
        t_rts_manual();
        t_rts_sweep();
        t_rts_needs_sw();
        t_irq();
        t_cts_idle();
        t_cts_midchar();
        t_cts_off();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule